// File: doc/BRIEF.md
# I2C Register-Access Target

This block is the target end of a two-wire I2C link that fronts a small register bank. Both bus lines are brought into the system-clock domain through a synchronizer, and the bus conditions and SCL edges are recovered there. After a START the block compares the incoming 7-bit address with its own. The low address bit of that address comes from a strap input. It then either accepts a register pointer followed by data bytes, or returns register contents starting at the current pointer. SDA is never driven high. The block only asks the pad to pull the line low, through an open-drain enable.

The register bank sits outside the block, behind a plain port. The port has a pointer output, a write strobe with write data, and a read-data input that must follow the pointer in the same cycle. The pointer survives STOP and repeated START. This allows a controller to set the pointer in a short write and then read back through a repeated START with the read bit set. Bursts in either direction step the pointer one register per byte. When the pointer runs off the top of the register space, it wraps to zero.

The system clock must run at least eight times faster than SCL. The enable and strap inputs are expected to be synchronous to the system clock and to change only while the bus is idle.

Top module: `i2c_reg_target`

## Requirements
- R1: A START (SDA falling while SCL is high) aborts whatever is in progress, including a partly received byte, and begins reception of an address byte. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. After reset SDA is released and no write strobe is given.
- R2: The first byte after a START is taken MSB first. Bits 7..1 are the address and bit 0 is the direction (0 = controller writes, 1 = controller reads). The block acknowledges when the address equals 0011100 with its last bit replaced by `addr_sel` (0x1C when low, 0x1D when high). To acknowledge, it holds SDA low through the whole ninth clock.
- R3: When the address does not match, the block gives no acknowledge, never drives SDA and issues no register writes until the next START.
- R4: In a write transfer, the first byte after the address loads the pointer from its low PTR_W bits. Each later byte is acknowledged and written to the register at the pointer with a one-cycle `reg_we` pulse, after which the pointer advances by one.
- R5: In a read transfer, the register at the pointer is returned MSB first. SDA is changed only while SCL is low.
- R6: During a read, a controller acknowledge advances the pointer and starts the next register. A controller NAK leaves the pointer unchanged and leaves SDA released until the next START.
- R7: The pointer is kept across STOP and repeated START, so a pointer write followed by a read returns the selected register.
- R8: The pointer wraps from 2^PTR_W-1 to 0 during write and read bursts.
- R9: While `enable` is low the block drives no SDA, issues no writes and ignores all bus traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block active when high, off mode when low |
| addr_sel | input | 1 | Strap for the low address bit |
| scl_in | input | 1 | SCL as seen at the pad |
| sda_in | input | 1 | SDA as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_addr | output | PTR_W | Register pointer |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_rdata | input | 8 | Register contents at reg_addr, same cycle |

## Verification
The assertions assume a well-behaved controller on an open-drain bus, and they rely on three things.
- SDA changes only while SCL is low, except to form START or STOP.
- Each SCL phase lasts long enough for the synchronizer to show it.
- `enable` changes only while SCL is steady.

The bench stays within these assumptions by building every bit from fixed phases of five system clocks each. It models SDA as the wired AND of the controller's drive and `sda_oe`, and it toggles `enable` only between transfers with the bus idle. Random pointers, lengths and data are mixed with directed cases: address mismatch on both strap settings, an aborted byte, pointer wrap, and a NAK-terminated burst.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, synced, prev_q;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= synced;
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = scl_s & ~prev_q[0];
  assign scl_fall  = ~scl_s & prev_q[0];
  assign start_det = scl_s & prev_q[0] & prev_q[1] & ~sda_s;
  assign stop_det  = scl_s & prev_q[0] & ~prev_q[1] & sda_s;
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int         PTR_W   = 4,
  parameter logic [5:0] ADDR_HI = 6'b001110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             addr_sel,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       reg_rdata,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we
);
  localparam logic [PTR_W-1:0] PTR_ONE  = 1;
  localparam logic [3:0]       BITS_IN  = 4'd8;
  localparam logic [3:0]       LAST_OUT = 4'd7;

  tgt_state_e       st_q, st_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       sh_q, sh_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             ptr_phase_q, ptr_phase_n;
  logic             rw_q, rw_n;
  logic             oe_q, oe_n;
  logic             mack_q, mack_n;
  logic             ptr_ld, we_c;
  logic [6:0]       own_addr;

  assign own_addr = {ADDR_HI, addr_sel};

  always_comb begin
    st_n        = st_q;
    cnt_n       = cnt_q;
    sh_n        = sh_q;
    ptr_n       = ptr_q;
    ptr_phase_n = ptr_phase_q;
    rw_n        = rw_q;
    oe_n        = oe_q;
    mack_n      = mack_q;
    ptr_ld      = 1'b0;
    we_c        = 1'b0;
    if (!enable) begin
      st_n        = ST_IDLE;
      oe_n        = 1'b0;
      ptr_phase_n = 1'b0;
    end else if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = 4'd0;
      oe_n  = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && cnt_q != BITS_IN) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end
          if (scl_fall && cnt_q == BITS_IN) begin
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == own_addr) begin
                st_n = ST_ADDR_ACK;
                oe_n = 1'b1;
                rw_n = sh_q[0];
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              st_n = ST_RX_ACK;
              oe_n = 1'b1;
              if (ptr_phase_q) begin
                ptr_n       = sh_q[PTR_W-1:0];
                ptr_ld      = 1'b1;
                ptr_phase_n = 1'b0;
              end else begin
                we_c  = 1'b1;
                ptr_n = ptr_q + PTR_ONE;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = 4'd0;
            if (rw_q) begin
              st_n = ST_TX;
              sh_n = reg_rdata;
              oe_n = ~reg_rdata[7];
            end else begin
              st_n        = ST_RX;
              oe_n        = 1'b0;
              ptr_phase_n = 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            st_n  = ST_RX;
            oe_n  = 1'b0;
            cnt_n = 4'd0;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST_OUT) begin
              st_n = ST_TX_ACK;
              oe_n = 1'b0;
            end else begin
              sh_n  = {sh_q[6:0], 1'b0};
              oe_n  = ~sh_q[6];
              cnt_n = cnt_q + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
            if (!sda_s) ptr_n = ptr_q + PTR_ONE;
          end
          if (scl_fall) begin
            if (mack_q) begin
              st_n  = ST_TX;
              sh_n  = reg_rdata;
              oe_n  = ~reg_rdata[7];
              cnt_n = 4'd0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= 4'd0;
      sh_q        <= 8'd0;
      ptr_q       <= '0;
      ptr_phase_q <= 1'b0;
      rw_q        <= 1'b0;
      oe_q        <= 1'b0;
      mack_q      <= 1'b0;
    end else begin
      st_q        <= st_n;
      cnt_q       <= cnt_n;
      sh_q        <= sh_n;
      ptr_q       <= ptr_n;
      ptr_phase_q <= ptr_phase_n;
      rw_q        <= rw_n;
      oe_q        <= oe_n;
      mack_q      <= mack_n;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = sh_q;
  assign reg_we    = we_c;

  // R1: a detected START always leads to address reception
  a_r1_start_enters_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start_det) |=> (st_q == ST_ADDR));

  // R2: the acknowledge is held for the whole ack slot
  a_r2_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR_ACK || st_q == ST_RX_ACK) |-> oe_q);

  // R4: every register write is followed by an acknowledge drive
  a_r4_write_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> oe_q);

  // R5: SDA drive is steady while SCL stays high
  a_r5_oe_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && enable && $past(enable)) |-> $stable(oe_q));

  // R8: apart from a pointer load the pointer only steps by one (with wrap)
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr_q) && !$past(ptr_ld)) |-> (ptr_q == $past(ptr_q) + PTR_ONE));

  // R9: off mode keeps the bus and the register port quiet
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (!oe_q && !reg_we));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int         PTR_W       = 4,
  parameter logic [5:0] ADDR_HI     = 6'b001110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             addr_sel,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic             reg_we,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata
);
  logic [1:0] rst_sq;
  logic       rst_int_n;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_int_n = rst_sq[1];

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_ctrl #(.PTR_W(PTR_W), .ADDR_HI(ADDR_HI)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .enable    (enable),
    .addr_sel  (addr_sel),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we)
  );
endmodule

// File: tb/tb_i2c_reg_target.sv
`timescale 1ns/1ps
module tb_i2c_reg_target;
  localparam int PW   = 4;
  localparam int NREG = 1 << PW;
  localparam int Q    = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, enable, addr_sel, scl, sda_m;
  logic          sda_oe, reg_we;
  logic [PW-1:0] reg_addr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic          sda_line;

  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_target dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .addr_sel(addr_sel),
    .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  logic [7:0] mem [NREG];
  logic [7:0] exp_mem [NREG];
  int         wr_cnt;
  assign reg_rdata = mem[reg_addr];

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [6:0] own_addr(input logic sel);
    return {6'b001110, sel};
  endfunction

  function automatic int wrap_idx(input int p, input int k);
    return (p + k) % NREG;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= init_val(i);
      wr_cnt <= 0;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt        <= wr_cnt + 1;
    end
  end

  int   checks = 0, failures = 0;
  int   hi_changes = 0, oe_cycles = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  logic done = 1'b0;

  always @(negedge clk) begin
    if (scl && scl_prev && (sda_oe !== oe_prev)) hi_changes++;
    if (sda_oe === 1'b1) oe_cycles++;
    scl_prev = scl;
    oe_prev  = sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wq(); scl = 1'b1; wq();
    ack = ~sda_line;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl = 1'b1; wq();
      d[i] = sda_line;
      wq(); scl = 1'b0; wq();
    end
    sda_m = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  // write transfer: address, pointer, n random data bytes; returns AND of acks
  task automatic do_write(input logic [6:0] a, input int p, input int n,
                          input logic upd, output logic all_ack);
    logic ak;
    logic [7:0] d;
    bus_start();
    put_byte({a, 1'b0}, ak); all_ack = ak;
    put_byte(8'(p), ak);     all_ack &= ak;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      put_byte(d, ak); all_ack &= ak;
      if (upd) exp_mem[wrap_idx(p, k)] = d;
    end
    bus_stop();
  endtask

  // random read: pointer write, repeated START, n bytes, last one NAKed
  task automatic do_read(input logic [6:0] a, input int p, input int n, input string tag);
    logic ak;
    logic [7:0] d;
    bus_start();
    put_byte({a, 1'b0}, ak);
    put_byte(8'(p), ak);
    bus_start();
    put_byte({a, 1'b1}, ak);
    chk({tag, " read ack"}, 32'(ak), 32'd1);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, d);
      chk(tag, 32'(d), 32'(exp_mem[wrap_idx(p, k)]));
    end
    bus_stop();
  endtask

  initial begin
    logic       ak;
    logic [7:0] d;
    int         w0, p, n;
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) exp_mem[i] = init_val(i);
    rst_n = 1'b0; enable = 1'b1; addr_sel = 1'b1; scl = 1'b1; sda_m = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset sda_oe", 32'(sda_oe), 32'd0);
    chk("R1 reset reg_we", 32'(reg_we), 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2/R4 directed write to 0x1D
    w0 = wr_cnt;
    do_write(own_addr(1'b1), 3, 2, 1'b1, ak);
    chk("R2 R4 write acks", 32'(ak), 32'd1);
    chk("R4 write count", 32'(wr_cnt - w0), 32'd2);
    chk("R4 reg3", 32'(mem[3]), 32'(exp_mem[3]));
    chk("R4 reg4", 32'(mem[4]), 32'(exp_mem[4]));
    chk("R1 released after stop", 32'(sda_oe), 32'd0);

    // R5/R6/R7 random read burst of two, NAK on the second
    do_read(own_addr(1'b1), 3, 2, "R5 R6 R7 burst read");

    // R6/R7 NAK kept the pointer at 4; new transfer reads with no pointer byte
    bus_start();
    put_byte({own_addr(1'b1), 1'b1}, ak);
    get_byte(1'b0, d);
    bus_stop();
    chk("R6 R7 pointer after NAK", 32'(d), 32'(exp_mem[4]));

    // R3 mismatch: 0x1C while strap is high
    w0 = wr_cnt; oe_cycles = 0;
    do_write(own_addr(1'b0), 6, 2, 1'b0, ak);
    chk("R3 no ack on mismatch", 32'(ak), 32'd0);
    chk("R3 no writes on mismatch", 32'(wr_cnt - w0), 32'd0);
    chk("R3 never drove sda", 32'(oe_cycles), 32'd0);
    chk("R3 reg6 untouched", 32'(mem[6]), 32'(exp_mem[6]));

    // R2 strap low: 0x1C acks, 0x1D does not
    addr_sel = 1'b0;
    do_write(own_addr(1'b0), 9, 1, 1'b1, ak);
    chk("R2 strap low ack", 32'(ak), 32'd1);
    chk("R2 R4 reg9", 32'(mem[9]), 32'(exp_mem[9]));
    oe_cycles = 0;
    do_write(own_addr(1'b1), 9, 1, 1'b0, ak);
    chk("R3 strap low rejects 0x1D", 32'(ak), 32'd0);
    chk("R3 reg9 kept", 32'(mem[9]), 32'(exp_mem[9]));
    chk("R3 strap low no drive", 32'(oe_cycles), 32'd0);
    addr_sel = 1'b1;

    // R8 wrap on write and read
    do_write(own_addr(1'b1), NREG - 1, 2, 1'b1, ak);
    chk("R8 wrap write acks", 32'(ak), 32'd1);
    chk("R8 top reg", 32'(mem[NREG-1]), 32'(exp_mem[NREG-1]));
    chk("R8 reg0 after wrap", 32'(mem[0]), 32'(exp_mem[0]));
    do_read(own_addr(1'b1), NREG - 1, 3, "R8 wrap read");

    // R1 START in the middle of a byte aborts it
    bus_start();
    put_byte({own_addr(1'b1), 1'b0}, ak);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    put_byte({own_addr(1'b1), 1'b0}, ak);
    chk("R1 restart address ack", 32'(ak), 32'd1);
    put_byte(8'd5, ak);
    d = 8'hA5;
    put_byte(d, ak);
    exp_mem[5] = d;
    bus_stop();
    chk("R1 write after abort", 32'(mem[5]), 32'h000000A5);

    // R9 off mode
    enable = 1'b0; w0 = wr_cnt; oe_cycles = 0;
    repeat (4) @(negedge clk);
    do_write(own_addr(1'b1), 2, 2, 1'b0, ak);
    chk("R9 no ack when off", 32'(ak), 32'd0);
    chk("R9 no writes when off", 32'(wr_cnt - w0), 32'd0);
    chk("R9 no drive when off", 32'(oe_cycles), 32'd0);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    do_read(own_addr(1'b1), 2, 1, "R9 reg2 kept");

    // random mix
    for (int it = 0; it < 25; it++) begin
      addr_sel = 1'($urandom);
      p = int'($urandom % NREG);
      n = 1 + int'($urandom % 4);
      do_write(own_addr(addr_sel), p, n, 1'b1, ak);
      chk("R4 random write acks", 32'(ak), 32'd1);
      do_read(own_addr(addr_sel), p, n, "R5 R6 random read");
    end

    chk("R5 sda steady while scl high", 32'(hi_changes), 32'd0);
    chk("R1 idle release", 32'(sda_oe), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule